// File: doc/BRIEF.md
# Timer compare waveform unit

This block is an 8-bit up-counter with one compare channel that shapes a single waveform output. A control register holds two fields. One field picks the waveform mode: free-running, clear-on-match (CTC) or fast PWM. The other picks the action the output takes on a compare match. The counter advances only on cycles where the external `tick` input is high, so a prescaler outside the block sets the count rate.

The output value is held in a register inside the block. When the action field takes over the pin, the block raises `waveOe`, but only if the pin's direction input is also set. In fast PWM mode, compare writes go to a holding copy that becomes active when the counter passes its top value. This avoids glitched periods. Two sticky flags report counter overflow and compare matches, and software clears each flag by writing a one to it.

A small register port reaches four addresses: 0 is control, 1 is compare, 2 is counter and 3 is flags. Writes take effect on the clock edge. Reads are combinational.

Top module: `tmr_wave_unit`

## Requirements
- R1: After reset every register reads zero, `waveOut` is 0, `waveOe` is 0 and both flags are 0.
- R2: Control register layout: bits 7:6 are the action field and bits 1:0 are the mode field (00 normal, 01 treated as normal, 10 CTC, 11 fast PWM). Bits 5:2 always read zero.
- R3: On each tick the counter increases by one, and it wraps from 255 to 0 in normal and fast PWM modes. A write to address 2 loads the counter.
- R4: In CTC mode, a tick taken while the counter equals the active compare value sets the counter to 0.
- R5: `waveOe` is 1 only when `pinDir` is 1 and the action field takes the pin. It takes the pin in non-PWM modes when the field is nonzero, and in fast PWM mode when the field is 10 or 11. Action 00, and action 01 in fast PWM mode, leave `waveOe` at 0.
- R6: A match is a tick taken while the counter equals the active compare value. In non-PWM modes a match toggles the output for action 01, clears it for 10 and sets it for 11, starting on the cycle after that tick.
- R7: In fast PWM with action 10, a match clears the output and a tick at counter 255 sets it.
- R8: In fast PWM with action 11, a match sets the output and a tick at counter 255 clears it.
- R9: In fast PWM with action 10 or 11 and a compare value of 255, the match action is dropped and only the action taken at 255 is applied. The output therefore stays at 1 for action 10 and at 0 for action 11.
- R10: Reads of address 1 return the last value written. In fast PWM mode that value becomes the active compare only after the next tick at counter 255. In other modes it is active at once.
- R11: A tick at counter 255 sets the overflow flag (flags bit 0), and a match sets the compare flag (flags bit 1). Writing a one to a flag bit clears that flag. If a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for one cycle |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 compare, 2 counter, 3 flags) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| pinDir | input | 1 | Pin direction bit; 1 allows the driver |
| waveOut | output | 1 | Waveform output value |
| waveOe | output | 1 | Output enable that overrides the normal port |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | 1 | Sticky compare flag |

## Verification
A wrong count shows up in the counter readback on the first tick after the fault. It also shifts later match positions, so `waveOut` edges arrive at the wrong tick. If the active compare is wrong, for example because the holding copy leaks through early in fast PWM, the compare flag or an output edge fires within the current period instead of the next. A wrong output register or a wrong action decode is visible on `waveOut` one cycle after the matching tick, or at the wrap at 255. The fast PWM top-value corner is the longest-latency case, because it needs a whole 256-tick period to show.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  typedef enum logic [1:0] {
    WGM_NORMAL = 2'b00,
    WGM_PHASE  = 2'b01,
    WGM_CTC    = 2'b10,
    WGM_FAST   = 2'b11
  } wgm_e;

  // Datapath conditions seen by the control
  typedef struct packed {
    logic atMatch;
    logic atTop;
    logic cmpIsTop;
  } status_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic cntClr;
    logic cmpLoad;
    logic cmpDirect;
    logic ocSet;
    logic ocClr;
    logic ocTgl;
  } strobe_t;
endpackage

// File: rtl/tmr_wave_ctrl.sv
module tmr_wave_ctrl
  import tmr_wave_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       ctrlWe,
  input  logic [1:0] comIn,
  input  logic [1:0] wgmIn,
  input  status_t    stat,
  output strobe_t    strb,
  output logic [7:0] ctrlRd,
  output logic       oeReq
);
  logic [1:0] comMode;
  wgm_e       wgm;
  logic       pwmMode, ctcMode, matchEv, topEv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      comMode <= 2'b00;
      wgm     <= WGM_NORMAL;
    end else if (ctrlWe) begin
      comMode <= comIn;
      wgm     <= wgm_e'(wgmIn);
    end
  end

  assign ctrlRd  = {comMode, 4'b0000, wgm};
  assign pwmMode = (wgm == WGM_FAST);
  assign ctcMode = (wgm == WGM_CTC);
  assign matchEv = tick & stat.atMatch;
  assign topEv   = tick & stat.atTop;
  assign oeReq   = pwmMode ? comMode[1] : (comMode != 2'b00);

  always_comb begin
    strb           = '0;
    strb.cntClr    = ctcMode & matchEv;
    strb.cmpLoad   = pwmMode & topEv;
    strb.cmpDirect = ~pwmMode;
    if (pwmMode) begin
      unique case (comMode)
        2'b10: begin
          strb.ocClr = matchEv & ~stat.cmpIsTop;
          strb.ocSet = topEv;
        end
        2'b11: begin
          strb.ocSet = matchEv & ~stat.cmpIsTop;
          strb.ocClr = topEv;
        end
        default: ;
      endcase
    end else begin
      unique case (comMode)
        2'b01:   strb.ocTgl = matchEv;
        2'b10:   strb.ocClr = matchEv;
        2'b11:   strb.ocSet = matchEv;
        default: ;
      endcase
    end
  end

  AST_OC_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ocSet, strb.ocClr, strb.ocTgl})); // R6
endmodule

// File: rtl/tmr_wave_dp.sv
module tmr_wave_dp
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  strobe_t          strb,
  input  logic             cmpWe,
  input  logic             cntWe,
  input  logic             flagWe,
  input  logic [REG_W-1:0] wdata,
  output status_t          stat,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmpBuf,
  output logic             ocOut,
  output logic             ovfFlag,
  output logic             cmpFlag
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cmpAct;

  assign stat.atMatch  = (cnt == cmpAct);
  assign stat.atTop    = (cnt == TOP);
  assign stat.cmpIsTop = (cmpAct == TOP);

  always_ff @(posedge clk) begin
    if (!rstN)                 cnt <= '0;
    else if (cntWe)            cnt <= wdata[CNT_W-1:0];
    else if (tick) begin
      if (strb.cntClr)         cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpBuf <= '0;
      cmpAct <= '0;
    end else begin
      if (cmpWe) cmpBuf <= wdata[CNT_W-1:0];
      if (cmpWe && strb.cmpDirect) cmpAct <= wdata[CNT_W-1:0];
      else if (strb.cmpLoad)       cmpAct <= cmpBuf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             ocOut <= 1'b0;
    else if (strb.ocTgl)   ocOut <= ~ocOut;
    else if (strb.ocSet)   ocOut <= 1'b1;
    else if (strb.ocClr)   ocOut <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      cmpFlag <= 1'b0;
    end else begin
      ovfFlag <= (tick & stat.atTop)   | (ovfFlag & ~(flagWe & wdata[0]));
      cmpFlag <= (tick & stat.atMatch) | (cmpFlag & ~(flagWe & wdata[1]));
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tick && !cntWe && !strb.cntClr |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    tick && cnt == TOP |=> ovfFlag); // R11
  AST_CMP_SET: assert property (@(posedge clk) disable iff (!rstN)
    tick && stat.atMatch |=> cmpFlag); // R11
endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       pinDir,
  output logic       waveOut,
  output logic       waveOe,
  output logic       ovfFlag,
  output logic       cmpFlag
);
  localparam logic [CNT_W-1:0] TOP = '1;

  status_t          stat;
  strobe_t          strb;
  logic [7:0]       ctrlRd;
  logic             oeReq;
  logic [CNT_W-1:0] cnt, cmpBuf;
  logic             ctrlWe, cmpWe, cntWe, flagWe;

  assign ctrlWe = regWe && (regAddr == ADDR_CTRL);
  assign cmpWe  = regWe && (regAddr == ADDR_CMP);
  assign cntWe  = regWe && (regAddr == ADDR_CNT);
  assign flagWe = regWe && (regAddr == ADDR_FLAG);

  tmr_wave_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .ctrlWe(ctrlWe),
    .comIn(regWdata[7:6]), .wgmIn(regWdata[1:0]),
    .stat(stat), .strb(strb), .ctrlRd(ctrlRd), .oeReq(oeReq)
  );

  tmr_wave_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .cmpWe(cmpWe), .cntWe(cntWe), .flagWe(flagWe), .wdata(regWdata),
    .stat(stat), .cnt(cnt), .cmpBuf(cmpBuf), .ocOut(waveOut),
    .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );

  assign waveOe = oeReq & pinDir;

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdata = ctrlRd;
      ADDR_CMP:  regRdata = 8'(cmpBuf);
      ADDR_CNT:  regRdata = 8'(cnt);
      default:   regRdata = {6'b0, cmpFlag, ovfFlag};
    endcase
  end

  AST_OE_NEEDS_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    waveOe |-> ctrlRd[7:6] != 2'b00 && pinDir); // R5
  AST_CTC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    tick && ctrlRd[1:0] == 2'b10 && stat.atMatch && !cntWe |=> cnt == '0); // R4
  AST_PWM_TOP_SET: assert property (@(posedge clk) disable iff (!rstN)
    tick && ctrlRd == 8'h83 && cnt == TOP |=> waveOut); // R7
  AST_PWM_TOP_CLR: assert property (@(posedge clk) disable iff (!rstN)
    tick && ctrlRd == 8'hC3 && cnt == TOP |=> !waveOut); // R8 R9
endmodule

// File: tb/tmr_wave_unit_tb.sv
module tmr_wave_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       pinDir = 1'b0;
  logic       waveOut, waveOe, ovfFlag, cmpFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_wave_unit dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinDir(pinDir),
    .waveOut(waveOut), .waveOe(waveOe), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  cmp;
    logic [7:0]  cnt;
    logic [15:0] ticks;
    logic        dir;
    logic        expOut;
    logic        expOe;
    logic [7:0]  expCnt;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{8'h40, 8'd5,   8'd3,   16'd3,   1'b1, 1'b1, 1'b1, 8'd6},   // R6 toggle
    '{8'h40, 8'd5,   8'd5,   16'd257, 1'b1, 1'b0, 1'b1, 8'd6},   // R6 toggle twice
    '{8'hC0, 8'd2,   8'd0,   16'd3,   1'b1, 1'b1, 1'b1, 8'd3},   // R6 set
    '{8'h00, 8'd1,   8'd0,   16'd2,   1'b1, 1'b0, 1'b0, 8'd2},   // R5 disconnected
    '{8'h40, 8'd5,   8'd3,   16'd3,   1'b0, 1'b1, 1'b0, 8'd6},   // R5 no direction
    '{8'h00, 8'd9,   8'd255, 16'd1,   1'b1, 1'b0, 1'b0, 8'd0},   // R3 wrap
    '{8'h42, 8'd3,   8'd0,   16'd4,   1'b1, 1'b1, 1'b1, 8'd0},   // R4 ctc
    '{8'h42, 8'd3,   8'd0,   16'd8,   1'b1, 1'b0, 1'b1, 8'd0},   // R4 ctc two periods
    '{8'h42, 8'd3,   8'd0,   16'd6,   1'b1, 1'b1, 1'b1, 8'd2},   // R4 ctc restart
    '{8'h83, 8'd10,  8'd250, 16'd6,   1'b1, 1'b1, 1'b1, 8'd0},   // R7 set at top
    '{8'h83, 8'd10,  8'd250, 16'd17,  1'b1, 1'b0, 1'b1, 8'd11},  // R7 clear at match
    '{8'hC3, 8'd10,  8'd250, 16'd17,  1'b1, 1'b1, 1'b1, 8'd11},  // R8 set at match
    '{8'hC3, 8'd10,  8'd250, 16'd6,   1'b1, 1'b0, 1'b1, 8'd0},   // R8 clear at top
    '{8'h83, 8'd255, 8'd250, 16'd262, 1'b1, 1'b1, 1'b1, 8'd0},   // R9 stays high
    '{8'hC3, 8'd255, 8'd250, 16'd262, 1'b1, 1'b0, 1'b1, 8'd0},   // R9 stays low
    '{8'h43, 8'd10,  8'd0,   16'd3,   1'b1, 1'b0, 1'b0, 8'd3}    // R5 pwm action 01
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tick = 1'b0; regWe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    pinDir = 1'b1;
    doReset();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1", "register after reset", v, 0);
    end
    chk("R1", "waveOut after reset", waveOut, 0);
    chk("R1", "waveOe after reset", waveOe, 0);
    chk("R1", "flags after reset", {cmpFlag, ovfFlag}, 0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      doReset();
      pinDir = VECS[i].dir;
      wr(2'd1, VECS[i].cmp);
      wr(2'd2, VECS[i].cnt);
      wr(2'd0, VECS[i].ctrl);
      ticks(int'(VECS[i].ticks));
      rd(2'd2, v);
      chk($sformatf("R3 vec%0d", i), "counter", v, VECS[i].expCnt);
      chk($sformatf("R6-8 vec%0d", i), "waveOut", waveOut, VECS[i].expOut);
      chk($sformatf("R5 vec%0d", i), "waveOe", waveOe, VECS[i].expOe);
    end
    pinDir = 1'b1;

    // R2 reserved bits
    doReset();
    wr(2'd0, 8'hFF);
    rd(2'd0, v);
    chk("R2", "control readback", v, 8'hC3);

    // R6 clear action after set
    doReset();
    wr(2'd1, 8'd2);
    wr(2'd0, 8'hC0);
    ticks(3);
    chk("R6", "set before clear", waveOut, 1);
    wr(2'd2, 8'd0);
    wr(2'd0, 8'h80);
    ticks(3);
    chk("R6", "clear on match", waveOut, 0);

    // R10 buffered compare in fast PWM
    doReset();
    wr(2'd1, 8'd50);
    wr(2'd2, 8'd40);
    wr(2'd0, 8'h83);
    wr(2'd1, 8'd200);
    rd(2'd1, v);
    chk("R10", "compare readback", v, 200);
    wr(2'd3, 8'h03);
    ticks(11);
    chk("R10", "old compare still active", cmpFlag, 1);
    wr(2'd3, 8'h02);
    wr(2'd2, 8'd250);
    ticks(6);
    wr(2'd2, 8'd50);
    ticks(1);
    chk("R10", "old compare replaced at top", cmpFlag, 0);
    // R10 direct in normal mode
    doReset();
    wr(2'd1, 8'd7);
    wr(2'd2, 8'd7);
    ticks(1);
    chk("R10", "direct compare write", cmpFlag, 1);

    // R11 flags
    doReset();
    wr(2'd1, 8'd100);
    wr(2'd2, 8'd254);
    ticks(2);
    chk("R11", "overflow set", ovfFlag, 1);
    chk("R11", "compare untouched", cmpFlag, 0);
    rd(2'd3, v);
    chk("R11", "flag readback", v, 1);
    wr(2'd2, 8'd100);
    ticks(1);
    chk("R11", "compare set", cmpFlag, 1);
    wr(2'd3, 8'h01);
    chk("R11", "overflow cleared", ovfFlag, 0);
    chk("R11", "compare kept", cmpFlag, 1);
    wr(2'd3, 8'h02);
    chk("R11", "compare cleared", cmpFlag, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule